// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block is the transfer datapath of one DMA channel. It holds a page value, a 16-bit current offset and a 16-bit current count. From these it forms the physical bus address for each transfer cycle. Each accepted advance strobe moves the offset forward by one unit and the count down by one unit. When the count runs out, the block raises a sticky terminal-count flag. The count is programmed as the number of units minus one. The residue output reports the units still to move, scaled to bytes.

A channel is loaded in either byte or word width. In byte width, the full 8-bit page selects a 64 KB window and the offset addresses bytes within it. In word width, the page's lowest bit is dropped and the offset is shifted left by one, so a 7-bit page selects a 128 KB window of 16-bit words. In both widths the offset wraps inside its window and never carries into the page. Request/acknowledge handshaking and bus cycle timing belong to the surrounding controller.

Top module: `dma_paged_engine`

## Requirements
- R1: In byte width, `phys_addr` equals the page value in bits 23:16 concatenated with the 16-bit current offset in bits 15:0.
- R2: In word width, `phys_addr` carries page bits 7:1 in bits 23:17, the current offset in bits 16:1, and 0 in bit 0. Page bit 0 has no effect on the address.
- R3: An advance at offset 0xFFFF wraps the offset to 0x0000 and leaves the page bits of `phys_addr` unchanged. Bits 23:17 of `phys_addr` change only on a load.
- R4: An accepted advance (`advance`=1, `masked`=0, terminal count not set, `load`=0) increments the offset by one and decrements the count by one at the next clock edge.
- R5: `load` copies `load_page`, `load_offset`, `load_count` and `load_word` into the channel and clears terminal count at the next edge. When `load` and `advance` are both high, the load takes priority.
- R6: An accepted advance while the count is 0x0000 sets `term_count`, wraps the count to 0xFFFF and makes `residue_bytes` 0. `term_count` stays set until the next load.
- R7: The advance strobe has no effect on the offset, the count or the flag while `masked` is 1 or `term_count` is 1.
- R8: While terminal count is clear, `residue_bytes` equals count+1 in byte width and 2*(count+1) in word width. It is 18 bits wide, so it reaches 0x10000 for a byte channel and 0x20000 for a word channel.
- R9: Synchronous active-high `rst` clears the page, the offset and the count, selects byte width and clears `term_count`. After reset, `phys_addr`=0, `residue_bytes`=1 and `word_xfer`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load the programmed values into the channel |
| load_page | input | 8 | Programmed page value |
| load_offset | input | 16 | Programmed start offset, in units |
| load_count | input | 16 | Programmed unit count minus one |
| load_word | input | 1 | Width selected at load: 1 for word, 0 for byte |
| masked | input | 1 | Channel masked; advance strobes are ignored |
| advance | input | 1 | One transfer unit has completed |
| phys_addr | output | 24 | Physical byte address of the current unit |
| word_xfer | output | 1 | Current transfer width is a 16-bit word |
| term_count | output | 1 | Sticky terminal-count flag |
| residue_bytes | output | 18 | Bytes still to move |

## Verification
The assertions assume that `rst` is high on the first clock edge and that every input changes only between edges. They also assume that `load` is the only path by which the page or the width can change, so any change to the upper address bits without a load counts as a fault. The stimulus drives all inputs on the falling edge and asserts reset before anything else happens. It exercises masked advances, advances after terminal count, and a load coinciding with an advance. It crosses the offset wrap point in both widths and loads both the smallest and the largest counts.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_width_e;
endpackage

// File: rtl/dma_unit_ctr.sv
module dma_unit_ctr
  import dma_page_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [OFS_W-1:0]  ld_ofs,
  input  logic [OFS_W-1:0]  ld_cnt,
  input  logic              ld_word,
  input  logic              masked,
  input  logic              advance,
  output logic [PAGE_W-1:0] page_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [OFS_W-1:0]  cnt_q,
  output xfer_width_e       width_q,
  output logic              tc_q
);
  localparam logic [OFS_W-1:0] CNT_ZERO = '0;

  logic step_ok;
  assign step_ok = advance && !masked && !tc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      ofs_q   <= '0;
      cnt_q   <= '0;
      width_q <= XFER_BYTE;
      tc_q    <= 1'b0;
    end else if (load) begin
      page_q  <= ld_page;
      ofs_q   <= ld_ofs;
      cnt_q   <= ld_cnt;
      width_q <= ld_word ? XFER_WORD : XFER_BYTE;
      tc_q    <= 1'b0;
    end else if (step_ok) begin
      ofs_q <= ofs_q + 1'b1;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_ZERO) tc_q <= 1'b1;
    end
  end

  // R4: one accepted strobe moves the count down by exactly one
  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !masked && !tc_q && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6: terminal count holds until a load
  assert_tc_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (tc_q && !load) |=> tc_q);

  // R7: a masked channel keeps offset and count
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (masked && !load) |=> ($stable(ofs_q) && $stable(cnt_q)));

  // R5: a load clears terminal count
  assert_load_clears_tc_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> !tc_q);
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
  import dma_page_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic [PAGE_W-1:0]       page,
  input  logic [OFS_W-1:0]        ofs,
  input  logic [OFS_W-1:0]        cnt,
  input  xfer_width_e             width,
  input  logic                    tc,
  output logic [PAGE_W+OFS_W-1:0] phys,
  output logic [OFS_W+1:0]        residue
);
  localparam int ADDR_W = PAGE_W + OFS_W;
  localparam int UNIT_W = OFS_W + 1;

  logic [ADDR_W-1:0] phys_byte;
  logic [ADDR_W-1:0] phys_word;
  logic [UNIT_W-1:0] units_left;

  assign phys_byte  = {page, ofs};
  assign phys_word  = {page[PAGE_W-1:1], ofs, 1'b0};
  assign units_left = tc ? '0 : ({1'b0, cnt} + 1'b1);

  always_comb begin
    if (width == XFER_WORD) begin
      phys    = phys_word;
      residue = {units_left, 1'b0};
    end else begin
      phys    = phys_byte;
      residue = {1'b0, units_left};
    end
  end
endmodule

// File: rtl/dma_paged_engine.sv
module dma_paged_engine
  import dma_page_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int ADDR_W = PAGE_W + OFS_W,
  localparam int RES_W  = OFS_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_page,
  input  logic [OFS_W-1:0]  load_offset,
  input  logic [OFS_W-1:0]  load_count,
  input  logic              load_word,
  input  logic              masked,
  input  logic              advance,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              word_xfer,
  output logic              term_count,
  output logic [RES_W-1:0]  residue_bytes
);
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [OFS_W-1:0]  cnt_q;
  xfer_width_e       width_q;
  logic              tc_q;

  dma_unit_ctr #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load),
    .ld_page(load_page), .ld_ofs(load_offset), .ld_cnt(load_count),
    .ld_word(load_word), .masked(masked), .advance(advance),
    .page_q(page_q), .ofs_q(ofs_q), .cnt_q(cnt_q),
    .width_q(width_q), .tc_q(tc_q)
  );

  dma_phys_map #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_map (
    .page(page_q), .ofs(ofs_q), .cnt(cnt_q), .width(width_q), .tc(tc_q),
    .phys(phys_addr), .residue(residue_bytes)
  );

  assign word_xfer  = (width_q == XFER_WORD);
  assign term_count = tc_q;

  // R3: the upper page bits never move without a load
  assert_page_no_carry_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> (phys_addr[ADDR_W-1:OFS_W+1] == $past(phys_addr[ADDR_W-1:OFS_W+1])));

  // R2: word addresses are even
  assert_word_even_R2: assert property (@(posedge clk) disable iff (rst)
    word_xfer |-> (phys_addr[0] == 1'b0));

  // R6: nothing is left once terminal count is reached
  assert_tc_residue_R6: assert property (@(posedge clk) disable iff (rst)
    term_count |-> (residue_bytes == '0));
endmodule

// File: tb/tb_dma_paged_engine.sv
module tb_dma_paged_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic        ld;
    logic        wd;
    logic        msk;
    logic        adv;
    logic [7:0]  page;
    logic [15:0] ofs;
    logic [15:0] cnt;
    logic [23:0] e_phys;
    logic [17:0] e_res;
    logic        e_tc;
    logic        e_word;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t TBL [NVEC] = '{
    '{1'b1,1'b0,1'b0,1'b0,8'h12,16'h3456,16'h0002,24'h123456,18'd3,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,16'h0000,16'h0000,24'h123457,18'd2,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,8'h00,16'h0000,16'h0000,24'h123457,18'd2,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,16'h0000,16'h0000,24'h123458,18'd1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,16'h0000,16'h0000,24'h123459,18'd0,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,16'h0000,16'h0000,24'h123459,18'd0,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,8'h35,16'hFFFF,16'h0001,24'h35FFFE,18'd4,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,16'h0000,16'h0000,24'h340000,18'd2,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,8'h80,16'h0010,16'h0005,24'h800010,18'd6,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'hFF,16'hFFFF,16'hFFFF,24'hFFFFFF,18'h10000,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,16'h0000,16'h0000,24'hFF0000,18'h0FFFF,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,8'h01,16'h0001,16'hFFFF,24'h000002,18'h20000,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000,16'h0000,24'h000002,18'h20000,1'b0,1'b1}
  };

  // requirement each table row exercises
  localparam string TAG [NVEC] = '{
    "R5/R1", "R4", "R7", "R4", "R6", "R7", "R2/R5", "R3", "R5", "R8", "R3", "R2/R8", "R8"
  };

  logic        clk = 1'b0;
  logic        rst, load, load_word, masked, advance;
  logic [7:0]  load_page;
  logic [15:0] load_offset, load_count;
  logic [23:0] phys_addr;
  logic        word_xfer, term_count;
  logic [17:0] residue_bytes;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_paged_engine dut (
    .clk(clk), .rst(rst), .load(load), .load_page(load_page),
    .load_offset(load_offset), .load_count(load_count), .load_word(load_word),
    .masked(masked), .advance(advance), .phys_addr(phys_addr),
    .word_xfer(word_xfer), .term_count(term_count), .residue_bytes(residue_bytes)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic wd, input logic msk,
                       input logic adv, input logic [7:0] pg,
                       input logic [15:0] of, input logic [15:0] ct);
    @(negedge clk);
    load = ld; load_word = wd; masked = msk; advance = adv;
    load_page = pg; load_offset = of; load_count = ct;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string req, input logic [23:0] ep,
                           input logic [17:0] er, input logic et, input logic ew);
    check(req, "phys_addr", {8'h0, phys_addr}, {8'h0, ep});
    check(req, "residue", {14'h0, residue_bytes}, {14'h0, er});
    check(req, "term_count", {31'h0, term_count}, {31'h0, et});
    check(req, "word_xfer", {31'h0, word_xfer}, {31'h0, ew});
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; load_word = 1'b0; masked = 1'b0; advance = 1'b0;
    load_page = '0; load_offset = '0; load_count = '0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000);
    // R9: reset state
    check_all("R9", 24'h000000, 18'd1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i].ld, TBL[i].wd, TBL[i].msk, TBL[i].adv,
            TBL[i].page, TBL[i].ofs, TBL[i].cnt);
      check_all(TAG[i], TBL[i].e_phys, TBL[i].e_res, TBL[i].e_tc, TBL[i].e_word);
    end

    // R6: word channel with a single unit reaches terminal count
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h0A, 16'h1000, 16'h0000);
    check_all("R8", 24'h0A2000, 18'd2, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h0000);
    check_all("R6", 24'h0A2002, 18'd0, 1'b1, 1'b1);
    // R7: strobe after terminal count leaves the address alone
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h0000);
    check_all("R7", 24'h0A2002, 18'd0, 1'b1, 1'b1);
    // R7: masked and idle strobes across several cycles
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h44, 16'h00FF, 16'h0010);
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 16'h0000, 16'h0000);
      check_all("R7", 24'h4400FF, 18'd17, 1'b0, 1'b0);
    end
    // R4: three accepted strobes in a row
    for (int k = 1; k <= 3; k++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h0000);
      check_all("R4", 24'h4400FF + 24'(k), 18'(17 - k), 1'b0, 1'b0);
    end
    // R9: reset during a loaded channel
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_all("R9", 24'h000000, 18'd1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule